// File: doc/BRIEF.md
# Cipher Accelerator Control Register Slave

This block is the AXI4-Lite register slave for a block-cipher accelerator made of several engines that share one configuration. Software uses it to choose the cipher direction and key length, to load a key of up to eight 32-bit words, and to run the one-shot key-expansion task through a start/done handshake. The engines receive a one-cycle start pulse, the shared settings and a key bus in which unused words are forced to zero. The engines return a completion pulse and one busy flag each.

Software starts key expansion by writing 1 to the start bit of the control word. The start bit stays set until the completion pulse arrives. The done bit then stays set until software reads the control word, and that read clears it. Encrypt/decrypt traffic itself needs no handshake here. This block only carries the settings that traffic uses.

Top module: `cipher_ctrl_regs`

## Requirements
- R1: After reset, every writable field is 0, the control word reads 0x04 (idle set), `cfg_key` is all zero, and `kx_start`, `s_bvalid` and `s_rvalid` are low.
- R2: A write to offset 0x000 with bit 0 set (byte lane 0 enabled) sets the start bit. Its rising edge gives exactly one `kx_start` cycle. Further start writes made while start is still set give no further pulse.
- R3: A `kx_done` cycle sets done (bit 1) and ready (bit 3) in the next cycle. The start bit is then cleared, and idle (bit 2) reads as the inverse of start.
- R4: Done stays set across reads of other offsets. A read of offset 0x000 returns done = 1 and clears it, so the next read of 0x000 shows done = 0.
- R5: Bit 4 of the control word (continue) has no effect when written and always reads 0.
- R6: Offset 0x010 bit 0 selects the direction (1 encrypt, 0 decrypt). It drives `cfg_encrypt` and reads back.
- R7: Offset 0x018 bits 1:0 hold the key-length code (00 = 128, 01 = 192, 10 = 256, 11 treated as 256). The code drives `cfg_keylen` and reads back.
- R8: Offset 0x020 returns `eng_busy` in bits 3:0 (1 = busy). Writes to it have no effect.
- R9: Key word k is at offset 0x028 + 8*(7-k) for k = 0..7. It reads back in full. Its stored value appears at `cfg_key[32k+31:32k]` whenever that word is in use.
- R10: With code 00, words 3..0 on `cfg_key` read as zero. With code 01, words 1..0 read as zero. With codes 10 and 11, all eight words pass through. Stored values stay readable whatever the code.
- R11: Each write changes only the byte lanes whose `s_wstrb` bit is set.
- R12: Reads of unmapped offsets return 0. Writes to them change nothing. Every response is OKAY (0).
- R13: A write completes the same way whether its address comes before, with, or after its data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | ADDR_W | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| kx_start | output | 1 | One-cycle key-expansion start pulse |
| kx_done | input | 1 | Key-expansion completion pulse |
| eng_busy | input | N_ENG | Per-engine busy flags |
| cfg_encrypt | output | 1 | 1 = encrypt, 0 = decrypt |
| cfg_keylen | output | 2 | Key-length code |
| cfg_key | output | 32*N_KEY | Key words, word k at bits 32k+31:32k, unused words zero |

## Verification
The bench builds the block with its defaults: an 8-bit address, four engines and eight key words. These values put every mapped offset within reach, along with unmapped holes both between the key words and above the last one. They also make every one of the four key-length codes selectable, so the masking of `cfg_key` can be checked for each code against the same stored key. The four status bits let a mixed busy pattern show whether status writes are really ignored.

// File: rtl/cipher_ctrl_regs.sv
module cipher_ctrl_regs #(
  parameter int ADDR_W = 8,
  parameter int N_ENG  = 4,
  parameter int N_KEY  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ADDR_W-1:0]     s_awaddr,
  input  logic                  s_awvalid,
  output logic                  s_awready,
  input  logic [31:0]           s_wdata,
  input  logic [3:0]            s_wstrb,
  input  logic                  s_wvalid,
  output logic                  s_wready,
  output logic [1:0]            s_bresp,
  output logic                  s_bvalid,
  input  logic                  s_bready,
  input  logic [ADDR_W-1:0]     s_araddr,
  input  logic                  s_arvalid,
  output logic                  s_arready,
  output logic [31:0]           s_rdata,
  output logic [1:0]            s_rresp,
  output logic                  s_rvalid,
  input  logic                  s_rready,
  output logic                  kx_start,
  input  logic                  kx_done,
  input  logic [N_ENG-1:0]      eng_busy,
  output logic                  cfg_encrypt,
  output logic [1:0]            cfg_keylen,
  output logic [32*N_KEY-1:0]   cfg_key
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] OFF_CTRL = WA_W'(8'h00 >> 2);
  localparam logic [WA_W-1:0] OFF_MODE = WA_W'(8'h10 >> 2);
  localparam logic [WA_W-1:0] OFF_KLEN = WA_W'(8'h18 >> 2);
  localparam logic [WA_W-1:0] OFF_STAT = WA_W'(8'h20 >> 2);
  localparam int KEY_BASE = 8'h28 >> 2;

  logic            aw_held, w_held;
  logic [WA_W-1:0] aw_wa;
  logic [31:0]     w_data;
  logic [3:0]      w_strb;
  logic            start_q, start_d, done_q;
  logic [31:0]     key_q [N_KEY];
  logic [31:0]     rd_mux;

  wire [WA_W-1:0] ar_wa = s_araddr[ADDR_W-1:2];
  wire unused_lsb = ^{s_araddr[1:0], s_awaddr[1:0]};
  wire wr_go = aw_held && w_held && !s_bvalid;
  wire ar_hs = s_arvalid && s_arready;
  wire rd_ctrl = ar_hs && (ar_wa == OFF_CTRL);
  wire wr_ctrl = wr_go && (aw_wa == OFF_CTRL) && w_strb[0];

  assign s_awready = !aw_held;
  assign s_wready  = !w_held;
  assign s_arready = !s_rvalid;
  assign s_bresp   = 2'b00;
  assign s_rresp   = 2'b00;
  assign kx_start  = start_q && !start_d;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held <= 1'b0;
      w_held  <= 1'b0;
      aw_wa   <= '0;
      w_data  <= '0;
      w_strb  <= '0;
      s_bvalid <= 1'b0;
    end else begin
      if (s_awvalid && s_awready) begin
        aw_held <= 1'b1;
        aw_wa   <= s_awaddr[ADDR_W-1:2];
      end else if (wr_go) aw_held <= 1'b0;
      if (s_wvalid && s_wready) begin
        w_held <= 1'b1;
        w_data <= s_wdata;
        w_strb <= s_wstrb;
      end else if (wr_go) w_held <= 1'b0;
      if (wr_go) s_bvalid <= 1'b1;
      else if (s_bready) s_bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      start_d <= 1'b0;
      done_q  <= 1'b0;
      cfg_encrypt <= 1'b0;
      cfg_keylen  <= 2'b00;
    end else begin
      start_d <= start_q;
      if (start_q) start_q <= !done_q;
      else if (wr_ctrl && w_data[0]) start_q <= 1'b1;
      if (kx_done) done_q <= 1'b1;
      else if (rd_ctrl) done_q <= 1'b0;
      if (wr_go && aw_wa == OFF_MODE && w_strb[0]) cfg_encrypt <= w_data[0];
      if (wr_go && aw_wa == OFF_KLEN && w_strb[0]) cfg_keylen <= w_data[1:0];
    end
  end

  for (genvar k = 0; k < N_KEY; k++) begin : g_key
    localparam logic [WA_W-1:0] OFF_K = WA_W'(KEY_BASE + 2 * (N_KEY - 1 - k));
    wire in_use = (k >= 4) || (k >= 2 && cfg_keylen != 2'b00) || cfg_keylen[1];
    always_ff @(posedge clk) begin
      if (!rst_n) key_q[k] <= '0;
      else if (wr_go && aw_wa == OFF_K)
        for (int b = 0; b < 4; b++)
          if (w_strb[b]) key_q[k][8*b +: 8] <= w_data[8*b +: 8];
    end
    assign cfg_key[32*k +: 32] = in_use ? key_q[k] : 32'h0;
  end

  always_comb begin
    rd_mux = 32'h0;
    if (ar_wa == OFF_CTRL) rd_mux = {27'h0, 1'b0, done_q, !start_q, done_q, start_q};
    if (ar_wa == OFF_MODE) rd_mux = {31'h0, cfg_encrypt};
    if (ar_wa == OFF_KLEN) rd_mux = {30'h0, cfg_keylen};
    if (ar_wa == OFF_STAT) rd_mux = 32'(eng_busy);
    for (int k = 0; k < N_KEY; k++)
      if (ar_wa == WA_W'(KEY_BASE + 2 * (N_KEY - 1 - k))) rd_mux = key_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s_rvalid <= 1'b0;
      s_rdata  <= '0;
    end else if (ar_hs) begin
      s_rvalid <= 1'b1;
      s_rdata  <= rd_mux;
    end else if (s_rready) s_rvalid <= 1'b0;
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    kx_start |=> !kx_start);
  a_r2_start_holds: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && !done_q |=> start_q);
  a_r3_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    kx_done |=> done_q);
  a_r3_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_q && done_q |=> !start_q);
  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !rd_ctrl |=> done_q);
  a_r12_bvalid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_bvalid && !s_bready |=> s_bvalid);
  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));
endmodule

// File: tb/cipher_ctrl_regs_tb.sv
module cipher_ctrl_regs_tb;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [7:0] s_awaddr = 0, s_araddr = 0;
  logic s_awvalid = 0, s_wvalid = 0, s_bready = 0, s_arvalid = 0, s_rready = 0;
  logic [31:0] s_wdata = 0;
  logic [3:0] s_wstrb = 0;
  logic s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0] s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic kx_start, kx_done = 0;
  logic [3:0] eng_busy = 4'b1010;
  logic cfg_encrypt;
  logic [1:0] cfg_keylen;
  logic [255:0] cfg_key;

  cipher_ctrl_regs u_dut (.*);

  int checks = 0, fails = 0, pulses = 0, cycles = 0;
  logic [31:0] kmodel [8];

  always @(posedge clk) begin
    cycles++;
    if (rst_n && kx_start) pulses++;
    if (cycles == 50000) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] s);
    for (int b = 0; b < 4; b++) if (s[b]) o[8*b +: 8] = n[8*b +: 8];
    return o;
  endfunction

  function automatic logic [255:0] masked_key(logic [1:0] kl);
    logic [255:0] r = '0;
    for (int k = 0; k < 8; k++)
      if (k >= 4 || (k >= 2 && kl != 0) || kl[1]) r[32*k +: 32] = kmodel[k];
    return r;
  endfunction

  function automatic logic [7:0] key_off(int k);
    return 8'(8'h28 + 8 * (7 - k));
  endfunction

  function automatic logic [31:0] ctrl_word(logic st, logic dn);
    return {28'h0, dn, !st, dn, st};
  endfunction

  task automatic axi_write(logic [7:0] a, logic [31:0] d, logic [3:0] s, int order);
    bit aw_ok = 0, w_ok = 0, aw_hs, w_hs;
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = s;
    if (order != 2) s_awvalid = 1;
    if (order != 1) s_wvalid = 1;
    while (!(aw_ok && w_ok)) begin
      #1;
      aw_hs = s_awvalid && s_awready;
      w_hs = s_wvalid && s_wready;
      @(negedge clk);
      if (aw_hs) begin s_awvalid = 0; aw_ok = 1; end
      if (w_hs) begin s_wvalid = 0; w_ok = 1; end
      if (order == 1 && aw_ok && !w_ok) s_wvalid = 1;
      if (order == 2 && w_ok && !aw_ok) s_awvalid = 1;
    end
    s_bready = 1;
    while (!s_bvalid) @(negedge clk);
    chk("R12 bresp", 256'(s_bresp), 256'(0));
    @(negedge clk);
    s_bready = 0;
  endtask

  task automatic axi_read(logic [7:0] a, output logic [31:0] d);
    bit hs;
    @(negedge clk);
    s_araddr = a; s_arvalid = 1; s_rready = 1;
    hs = 0;
    while (!hs) begin
      #1;
      hs = s_arready;
      @(negedge clk);
    end
    s_arvalid = 0;
    while (!s_rvalid) @(negedge clk);
    d = s_rdata;
    chk("R12 rresp", 256'(s_rresp), 256'(0));
    @(negedge clk);
    s_rready = 0;
  endtask

  initial begin
    logic [31:0] rd, v;
    logic [3:0] st;
    int k, ord;
    void'($urandom(32'h5eed));
    for (int i = 0; i < 8; i++) kmodel[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 outputs", 256'({kx_start, s_bvalid, s_rvalid, cfg_encrypt, cfg_keylen}), 256'(0));
    chk("R1 cfg_key", cfg_key, 256'(0));
    axi_read(8'h00, rd);
    chk("R1 ctrl", 256'(rd), 256'(ctrl_word(0, 0)));

    axi_write(8'h10, 32'h1, 4'h1, 0);
    chk("R6 cfg_encrypt", 256'(cfg_encrypt), 256'(1));
    axi_read(8'h10, rd);
    chk("R6 readback", 256'(rd), 256'(1));
    axi_write(8'h10, 32'h0, 4'h0, 0);
    chk("R11 strobe off", 256'(cfg_encrypt), 256'(1));
    axi_write(8'h18, 32'h2, 4'h1, 1);
    chk("R7 cfg_keylen", 256'(cfg_keylen), 256'(2));
    axi_read(8'h18, rd);
    chk("R7 readback", 256'(rd), 256'(2));

    axi_read(8'h20, rd);
    chk("R8 status", 256'(rd), 256'(4'b1010));
    axi_write(8'h20, 32'h5, 4'hF, 0);
    eng_busy = 4'b0110;
    axi_read(8'h20, rd);
    chk("R8 status after write", 256'(rd), 256'(4'b0110));

    axi_write(8'h00, 32'h11, 4'h1, 0);
    repeat (2) @(negedge clk);
    chk("R2 one pulse", 256'(pulses), 256'(1));
    axi_read(8'h00, rd);
    chk("R2 R5 start held, continue 0", 256'(rd), 256'(ctrl_word(1, 0)));
    axi_write(8'h00, 32'h1, 4'h1, 2);
    repeat (2) @(negedge clk);
    chk("R2 no repeat pulse", 256'(pulses), 256'(1));
    kx_done = 1;
    @(negedge clk);
    kx_done = 0;
    repeat (2) @(negedge clk);
    axi_read(8'h20, rd);
    axi_read(8'h00, rd);
    chk("R3 R4 done ready idle", 256'(rd), 256'(ctrl_word(0, 1)));
    axi_read(8'h00, rd);
    chk("R4 cleared by read", 256'(rd), 256'(ctrl_word(0, 0)));

    for (int i = 0; i < 40; i++) begin
      k = $urandom_range(0, 7);
      v = $urandom;
      st = 4'($urandom);
      ord = $urandom_range(0, 2);
      axi_write(key_off(k), v, st, ord);
      kmodel[k] = merge(kmodel[k], v, st);
    end
    axi_write(key_off(3), 32'hA5A5_0001, 4'hF, 2);
    kmodel[3] = 32'hA5A5_0001;
    for (int i = 0; i < 8; i++) begin
      axi_read(key_off(i), rd);
      chk("R9 R11 R13 key readback", 256'(rd), 256'(kmodel[i]));
    end
    for (int c = 0; c < 4; c++) begin
      axi_write(8'h18, 32'(c), 4'h1, c % 3);
      chk("R10 R9 cfg_key mask", cfg_key, masked_key(2'(c)));
    end
    axi_read(key_off(0), rd);
    chk("R10 stored kept", 256'(rd), 256'(kmodel[0]));

    axi_read(8'h08, rd);
    chk("R12 unmapped 0x08", 256'(rd), 256'(0));
    axi_read(8'h2C, rd);
    chk("R12 unmapped 0x2C", 256'(rd), 256'(0));
    axi_read(8'hFC, rd);
    chk("R12 unmapped 0xFC", 256'(rd), 256'(0));
    axi_write(8'h08, 32'hFFFF_FFFF, 4'hF, 0);
    axi_write(8'h2C, 32'hFFFF_FFFF, 4'hF, 1);
    axi_read(8'h10, rd);
    chk("R12 mode untouched", 256'(rd), 256'(1));
    axi_read(8'h00, rd);
    chk("R12 ctrl untouched", 256'(rd), 256'(ctrl_word(0, 0)));
    chk("R12 key untouched", cfg_key, masked_key(2'd3));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule